// File: doc/BRIEF.md
# Correlating Two-Level Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a global record of the outcomes of the most recent branches. That record picks one of several pattern tables. The low bits of the branch address then pick one saturating counter inside the chosen table, and the upper bit of that counter is the guess. The number of history bits, the number of address bits used and the counter width are all parameters. With zero history bits the block reduces to a single table of counters indexed only by address.

Fetch logic presents a branch address on the predict port and reads the guess in the same cycle. It also receives the history value that chose the table. When the branch later resolves, the pipeline returns the same address, the captured history and the real outcome on the resolve port. The addressed counter then moves one step toward that outcome, and the outcome is shifted into the history.

Top module: `gap_predictor`

## Requirements
- R1: After reset every counter holds the value one below half scale (binary 01 for 2-bit counters, weakly not taken) and the history is zero, so every address is predicted not taken (predTaken = 0) and predHist reads 0.
- R2: predTaken is combinational and equals the most significant bit of the counter at table predHist, entry predPc[IDX_W-1:0]; 1 means taken. predHist shows the current history.
- R3: A resolve with resTaken = 1 raises the counter at table resHist, entry resPc[IDX_W-1:0] by one, holding at the all-ones value.
- R4: A resolve with resTaken = 0 lowers that counter by one, holding at zero. With 2-bit counters a strongly taken entry therefore needs two not-taken resolves before its prediction flips.
- R5: On each resolve the history shifts left by one, the outcome enters bit 0 and the oldest bit is dropped; without a resolve the history is unchanged, and predict requests never alter any state.
- R6: The update goes to the table named by resHist, not the current history, so one address keeps independent counters in each table.
- R7: A prediction made in the same cycle as a resolve to the same counter sees the value from before that update.
- R8: With HIST_W = 0 the block is a single table of 2^IDX_W counters indexed by address only; predHist reads 0 and resHist is ignored.
- R9: Address bits at and above IDX_W have no effect on prediction or update, so addresses that agree in their low IDX_W bits share a counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| predPc | input | PC_W | Branch address to predict |
| predTaken | output | 1 | Guess for predPc, 1 = taken |
| predHist | output | max(1,HIST_W) | History value that chose the table for this guess |
| resValid | input | 1 | A branch resolves this cycle |
| resPc | input | PC_W | Address of the resolving branch |
| resHist | input | max(1,HIST_W) | History captured when that branch was predicted |
| resTaken | input | 1 | Actual outcome, 1 = taken |

## Verification
A counter that stepped wrongly or missed its saturation limit shows on predTaken only when that exact table and entry is read again. It stays hidden until the history returns to that table, and even then only if the error moves the counter across its midpoint. A corrupted history shows at once on predHist in the cycle after the resolve. It then sends later guesses to the wrong table. The bench therefore compares predHist and predTaken on every cycle against a full model of all counters, and it steers the history back to chosen tables so that saturation and table independence become visible.

// File: rtl/gap_pkg.sv
package gap_pkg;
  typedef struct packed {
    logic wrEn;
    logic up;
    logic shiftEn;
  } gap_strobe_t;
endpackage

// File: rtl/gap_ctrl.sv
module gap_ctrl
  import gap_pkg::*;
#(
  parameter int CTR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             resValid,
  input  logic             resTaken,
  input  logic [CTR_W-1:0] rdCtr,
  output gap_strobe_t      strobe
);
  localparam logic [CTR_W-1:0] CMAX = {CTR_W{1'b1}};

  logic atTop;
  logic atBottom;

  assign atTop    = (rdCtr == CMAX);
  assign atBottom = (rdCtr == '0);

  always_comb begin
    strobe.shiftEn = resValid;
    strobe.up      = resTaken;
    strobe.wrEn    = resValid && (resTaken ? !atTop : !atBottom);
  end

  // R5: nothing moves without a resolve
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !resValid |-> (!strobe.wrEn && !strobe.shiftEn));
endmodule

// File: rtl/gap_datapath.sv
module gap_datapath
  import gap_pkg::*;
#(
  parameter int HIST_W = 2,
  parameter int IDX_W  = 4,
  parameter int CTR_W  = 2,
  parameter int PC_W   = 16,
  localparam int HW    = (HIST_W > 0) ? HIST_W : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PC_W-1:0]  predPc,
  input  logic             resValid,
  input  logic [PC_W-1:0]  resPc,
  input  logic [HW-1:0]    resHist,
  input  logic             resTaken,
  input  gap_strobe_t      strobe,
  output logic             predBit,
  output logic [HW-1:0]    predHist,
  output logic [CTR_W-1:0] rdCtr
);
  localparam int FW      = HIST_W + IDX_W;
  localparam int ENTRIES = 1 << FW;
  localparam logic [CTR_W-1:0] CMAX  = {CTR_W{1'b1}};
  localparam logic [CTR_W-1:0] CINIT = CTR_W'((1 << (CTR_W - 1)) - 1);
  localparam logic [CTR_W-1:0] CONE  = CTR_W'(1);

  logic [HW-1:0]    histQ;
  logic [FW-1:0]    predFull;
  logic [FW-1:0]    resFull;
  logic [CTR_W-1:0] ctrMem [ENTRIES];
  logic             pcHiUnused;

  assign pcHiUnused = ^{predPc[PC_W-1:IDX_W], resPc[PC_W-1:IDX_W]};

  generate
    if (HIST_W == 0) begin : g_bimodal
      logic histUnused;
      assign histUnused = ^{resHist, resTaken, strobe.shiftEn, resValid};
      assign histQ    = '0;
      assign predFull = predPc[IDX_W-1:0];
      assign resFull  = resPc[IDX_W-1:0];
    end else begin : g_corr
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          histQ <= '0;
        else if (strobe.shiftEn) begin
          if (HIST_W == 1) histQ <= resTaken;
          else             histQ <= {histQ[HW-2:0], resTaken};
        end
      end
      assign predFull = {histQ, predPc[IDX_W-1:0]};
      assign resFull  = {resHist, resPc[IDX_W-1:0]};

      if (HIST_W == 1) begin : g_h1
        a_r5_hist_shift: assert property (@(posedge clk) disable iff (!rst_n)
          resValid |=> (histQ[0] == $past(resTaken)));
      end else begin : g_hn
        a_r5_hist_shift: assert property (@(posedge clk) disable iff (!rst_n)
          resValid |=> (histQ == {$past(histQ[HW-2:0]), $past(resTaken)}));
      end
      a_r5_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !resValid |=> $stable(histQ));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) ctrMem[i] <= CINIT;
    end else if (strobe.wrEn) begin
      ctrMem[resFull] <= strobe.up ? (ctrMem[resFull] + CONE)
                                   : (ctrMem[resFull] - CONE);
    end
  end

  assign rdCtr    = ctrMem[resFull];
  assign predBit  = ctrMem[predFull][CTR_W-1];
  assign predHist = histQ;

  // R3: taken resolve steps up, holding at the top
  a_r3_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (resValid && resTaken) |=>
      (ctrMem[$past(resFull)] ==
       (($past(rdCtr) == CMAX) ? CMAX : ($past(rdCtr) + CONE))));

  // R4: not-taken resolve steps down, holding at zero
  a_r4_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (resValid && !resTaken) |=>
      (ctrMem[$past(resFull)] ==
       (($past(rdCtr) == '0) ? '0 : ($past(rdCtr) - CONE))));
endmodule

// File: rtl/gap_predictor.sv
module gap_predictor
  import gap_pkg::*;
#(
  parameter int HIST_W = 2,
  parameter int IDX_W  = 4,
  parameter int CTR_W  = 2,
  parameter int PC_W   = 16,
  localparam int HW    = (HIST_W > 0) ? HIST_W : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] predPc,
  output logic            predTaken,
  output logic [HW-1:0]   predHist,
  input  logic            resValid,
  input  logic [PC_W-1:0] resPc,
  input  logic [HW-1:0]   resHist,
  input  logic            resTaken
);
  gap_strobe_t      strobe;
  logic [CTR_W-1:0] rdCtr;

  gap_ctrl #(.CTR_W(CTR_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .resValid(resValid), .resTaken(resTaken),
    .rdCtr(rdCtr), .strobe(strobe)
  );

  gap_datapath #(.HIST_W(HIST_W), .IDX_W(IDX_W), .CTR_W(CTR_W), .PC_W(PC_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .predPc(predPc), .resValid(resValid),
    .resPc(resPc), .resHist(resHist), .resTaken(resTaken), .strobe(strobe),
    .predBit(predTaken), .predHist(predHist), .rdCtr(rdCtr)
  );
endmodule

// File: tb/gap_predictor_tb_top.sv
module gap_predictor_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] predPc = '0;
  logic        resValid = 1'b0;
  logic [15:0] resPc = '0;
  logic [1:0]  resHist = '0;
  logic        resTaken = 1'b0;
  logic        predTaken;
  logic [1:0]  predHist;
  logic        bmTaken;
  logic [0:0]  bmHist;

  int checks = 0;
  int errors = 0;

  logic [1:0] expC [64];
  logic [1:0] expB [16];
  logic [1:0] hist;

  always #(CLK_PERIOD/2) clk = ~clk;

  gap_predictor #(.HIST_W(2), .IDX_W(4), .CTR_W(2), .PC_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .predPc(predPc), .predTaken(predTaken),
    .predHist(predHist), .resValid(resValid), .resPc(resPc),
    .resHist(resHist), .resTaken(resTaken)
  );

  gap_predictor #(.HIST_W(0), .IDX_W(4), .CTR_W(2), .PC_W(16)) bimodal_i (
    .clk(clk), .rst_n(rst_n), .predPc(predPc), .predTaken(bmTaken),
    .predHist(bmHist), .resValid(resValid), .resPc(resPc),
    .resHist(resHist[0:0]), .resTaken(resTaken)
  );

  function automatic logic [1:0] satStep(input logic [1:0] c, input logic t);
    if (t) return (c == 2'b11) ? c : c + 2'b01;
    return (c == 2'b00) ? c : c - 2'b01;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [15:0] pPc, input logic rv, input logic [15:0] rPc,
                      input logic [1:0] rH, input logic rT, input string tag);
    @(negedge clk);
    predPc = pPc; resValid = rv; resPc = rPc; resHist = rH; resTaken = rT;
    #1;
    chk(tag, {31'd0, predTaken}, {31'd0, expC[{hist, pPc[3:0]}][1]});
    chk({tag, " hist"}, {30'd0, predHist}, {30'd0, hist});
    chk("R8 bimodal", {31'd0, bmTaken}, {31'd0, expB[pPc[3:0]][1]});
    chk("R8 bimodal hist", {31'd0, bmHist}, 32'd0);
    @(posedge clk);
    if (rv) begin
      expC[{rH, rPc[3:0]}] = satStep(expC[{rH, rPc[3:0]}], rT);
      expB[rPc[3:0]]       = satStep(expB[rPc[3:0]], rT);
      hist = {hist[0], rT};
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) expC[i] = 2'b01;
    for (int i = 0; i < 16; i++) expB[i] = 2'b01;
    hist = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, every entry of table 0 weakly not taken
    for (int e = 0; e < 16; e++) step(16'(e), 1'b0, 16'd0, 2'd0, 1'b0, "R1");

    // R3: four taken resolves to table 0 entry 3 saturate at 11
    for (int k = 0; k < 4; k++) step(16'd3, 1'b1, 16'd3, 2'd0, 1'b1, "R3");
    // R5: two not-taken resolves bring history back to 00
    step(16'd3, 1'b1, 16'd9, 2'd3, 1'b0, "R5");
    step(16'd3, 1'b1, 16'd9, 2'd3, 1'b0, "R5");
    step(16'd3, 1'b0, 16'd0, 2'd0, 1'b0, "R3");
    // R4: two misses needed before the guess flips, then hold at 00
    step(16'd3, 1'b1, 16'd3, 2'd0, 1'b0, "R4");
    step(16'd3, 1'b1, 16'd3, 2'd0, 1'b0, "R4");
    step(16'd3, 1'b1, 16'd3, 2'd0, 1'b0, "R4");
    step(16'd3, 1'b1, 16'd3, 2'd0, 1'b0, "R4");
    step(16'd3, 1'b0, 16'd0, 2'd0, 1'b0, "R4");

    // R6: train table 3 entry 7, table 0 entry 7 untouched
    step(16'd7, 1'b1, 16'd7, 2'd3, 1'b1, "R6");
    step(16'd7, 1'b1, 16'd7, 2'd3, 1'b1, "R6");
    step(16'd7, 1'b0, 16'd0, 2'd0, 1'b0, "R6");
    step(16'd7, 1'b1, 16'd9, 2'd3, 1'b0, "R6");
    step(16'd7, 1'b1, 16'd9, 2'd3, 1'b0, "R6");
    step(16'd7, 1'b0, 16'd0, 2'd0, 1'b0, "R6");

    // R7: predict and resolve of the same counter in one cycle
    step(16'd12, 1'b1, 16'd12, 2'd0, 1'b1, "R7");
    step(16'd12, 1'b1, 16'd12, 2'd0, 1'b1, "R7");

    // R9: upper address bits alias onto the same counter
    step(16'hAB05, 1'b1, 16'h1205, hist, 1'b1, "R9");
    step(16'h0005, 1'b1, 16'hFF05, hist, 1'b1, "R9");
    step(16'h7705, 1'b0, 16'd0, 2'd0, 1'b0, "R9");

    // R2: random mix, history either correctly captured or arbitrary
    for (int n = 0; n < 1500; n++) begin
      logic [15:0] pp;
      logic [15:0] rp;
      logic [1:0]  rh;
      pp = 16'($urandom);
      rp = 16'($urandom);
      rh = ($urandom % 4 != 0) ? hist : 2'($urandom);
      step(pp, 1'($urandom), rp, rh, 1'($urandom), "R2");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule